// File: doc/BRIEF.md
# DSI Command Packet Transmit Builder

This block turns a single command request into the 32-bit words that a DSI host pushes into its transmit FIFO. A request carries a 6-bit data type, a 2-bit virtual channel and a 16-bit argument. For a short packet the argument is a parameter pair. For a long packet it is the payload length in bytes, and the payload then streams in one byte per accepted beat. Two flags mark requests that expect an acknowledge or a read response. The block forms the header word and computes its check byte in hardware. It packs the payload little-endian into words and tags every word with the FIFO it belongs in: the small host FIFO, or the large video FIFO for packets that do not fit the host FIFO.

A packet too large for the video FIFO is refused at once with a no-space status and produces no output. An accepted request first clears the FIFOs if the underflow or overflow flag was set when it was taken. The block then emits its words and raises a transmit trigger. It holds the trigger until the downstream side reports completion, or until a programmable cycle budget runs out, which ends the transfer with a timeout status. When a response is expected, a one-cycle bus turnaround request follows a successful trigger. The transfer ends with a one-cycle completion pulse that carries a status and a byte count.

Top module: `dsi_cmd_tx`

## Requirements
- R1: Each emitted packet begins with a header word laid out as follows. Bits [7:0] are {virtual channel, data type}, with the channel in [7:6]. Bits [15:8] hold the low byte and bits [23:16] the high byte of the argument, which for a long packet is the payload length. Bits [29:24] hold the check byte and bits [31:30] are zero.
- R2: The check byte is the XOR of one 6-bit syndrome for each set bit i of header bits [23:0]. The syndromes for i = 0..23, in hex, are 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B.
- R3: A long packet's payload bytes follow the header, four per word, with the first byte in bits [7:0]. A final partial word is padded with zero bytes. A short packet takes no payload beats and is a single word.
- R4: The packet size is 4 bytes plus the payload length, where a short packet has length 0. `wd_vfifo` is 1 on every word of a packet exactly when the size exceeds HOST_WORDS*4.
- R5: A request whose size exceeds VIDEO_WORDS*4 completes in the cycle after acceptance with status 1 (no space) and count 0. It emits no word, no trigger, no FIFO reset and no turnaround.
- R6: After its last word, an accepted packet holds `tx_trig` high until `trig_clr` is sampled high. It then completes with status 0.
- R7: If `trig_clr` has not been sampled high within `cfg_timeout` cycles of `tx_trig`, the transfer completes with status 2 (timeout) and count 0. `tx_trig` stays high for exactly `cfg_timeout` cycles, and no turnaround is requested. A clear sampled in the last allowed cycle still succeeds.
- R8: `bta_req` pulses for one cycle, between the trigger clearing and `done`, exactly when the transfer succeeded and the request had the acknowledge or the read flag set.
- R9: On success without a turnaround, `done_count` is 4 plus the payload length. With a turnaround it is 0.
- R10: When `fifo_uflow` or `fifo_oflow` is high in the cycle a request is accepted, and the request is not refused, `fifo_rst` pulses for one cycle before the header word. Otherwise `fifo_rst` stays low.
- R11: `req_ready` is high only while the block is idle, which is also its state after reset. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timeout | input | TO_W | Trigger cycle budget |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_dtype | input | 6 | Packet data type |
| req_vc | input | 2 | Virtual channel |
| req_long | input | 1 | 1 for a long packet |
| req_arg | input | 16 | Parameter pair (short) or payload length (long) |
| req_ack | input | 1 | Acknowledge requested |
| req_read | input | 1 | Read response expected |
| fifo_uflow | input | 1 | Transmit FIFO underflow flag |
| fifo_oflow | input | 1 | Transmit FIFO overflow flag |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte taken this cycle |
| pay_byte | input | 8 | Payload byte |
| fifo_rst | output | 1 | FIFO reset pulse |
| wd_valid | output | 1 | Word valid |
| wd_data | output | 32 | Packet word |
| wd_vfifo | output | 1 | Word goes to the video FIFO |
| tx_trig | output | 1 | Transmit trigger pending |
| trig_clr | input | 1 | Downstream reports transmission complete |
| bta_req | output | 1 | Bus turnaround request pulse |
| done | output | 1 | Transfer complete pulse |
| done_status | output | 2 | 0 ok, 1 no space, 2 timeout |
| done_count | output | 17 | Completion byte count |

## Verification
The bench builds the block with HOST_WORDS = 4 and VIDEO_WORDS = 8, so the host FIFO limit falls at 16 bytes and the refusal limit at 32 bytes. Payloads of 12, 13, 28 and 29 bytes then sit directly on both edges and need only a few dozen cycles each. TO_W = 8 with a small run-time `cfg_timeout` puts the timeout edge within reach. The bench clears the trigger exactly at the budget and one cycle past it, and also lets it expire with a turnaround-requesting command.

// File: rtl/dsi_tx_pkg.sv
package dsi_tx_pkg;

    localparam int HDR_BYTES = 4;
    localparam int CNT_W     = 17;

    typedef enum logic [1:0] {
        XS_OK      = 2'd0,
        XS_NOSPACE = 2'd1,
        XS_TIMEOUT = 2'd2
    } xfer_status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FLUSH,
        PH_HEAD,
        PH_BODY,
        PH_KICK,
        PH_TURN,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic [5:0]  dtype;
        logic [1:0]  vc;
        logic        is_long;
        logic [15:0] arg;
        logic        want_bta;
    } cmd_t;

    // parity-bit membership masks over the 24 header bits
    localparam logic [23:0] ECC_MASK [6] = '{
        24'hF12CB7, 24'hF2555B, 24'h749A6D,
        24'hB8E38E, 24'hDF03F0, 24'hEFFC00
    };

    function automatic logic [5:0] hdr_ecc(input logic [23:0] h);
        logic [5:0] e;
        for (int k = 0; k < 6; k++) begin
            e[k] = ^(h & ECC_MASK[k]);
        end
        return e;
    endfunction

    function automatic logic [31:0] hdr_word(input cmd_t c);
        logic [7:0]  id;
        logic [23:0] body;
        id   = {c.vc, c.dtype};
        body = {c.arg, id};
        return {2'b00, hdr_ecc(body), body};
    endfunction

endpackage

// File: rtl/dsi_tx_hdr.sv
module dsi_tx_hdr
    import dsi_tx_pkg::*;
(
    input  cmd_t        cmd,
    output logic [31:0] word
);
    assign word = hdr_word(cmd);
endmodule

// File: rtl/dsi_tx_packer.sv
module dsi_tx_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        last,
    input  logic [7:0]  data,
    output logic        word_valid,
    output logic [31:0] word
);
    logic [31:0] acc;
    logic [1:0]  lane;
    logic [31:0] merged;

    always_comb begin
        merged = acc;
        merged[lane*8 +: 8] = data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            lane       <= '0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= 1'b0;
            if (take) begin
                if (lane == 2'd3 || last) begin
                    word       <= merged;
                    word_valid <= 1'b1;
                    acc        <= '0;
                    lane       <= '0;
                end else begin
                    acc  <= merged;
                    lane <= lane + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/dsi_tx_seq.sv
module dsi_tx_seq
    import dsi_tx_pkg::*;
#(
    parameter int HOST_WORDS  = 64,
    parameter int VIDEO_WORDS = 480,
    parameter int TO_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TO_W-1:0]  cfg_timeout,
    input  logic             req_valid,
    input  cmd_t             req_cmd,
    input  logic             fifo_bad,
    input  logic             pay_valid,
    input  logic             trig_clr,
    output logic             req_ready,
    output logic             flush,
    output logic             head_now,
    output logic             pay_ready,
    output logic             pay_last,
    output logic             tx_trig,
    output logic             bta_req,
    output logic             done,
    output xfer_status_e     status,
    output logic [CNT_W-1:0] count,
    output logic             vfifo,
    output cmd_t             cmd
);
    localparam logic [31:0] HOST_BYTES  = 32'(HOST_WORDS * 4);
    localparam logic [31:0] VIDEO_BYTES = 32'(VIDEO_WORDS * 4);

    phase_e            phase;
    logic [15:0]       remain;
    logic [TO_W-1:0]   timer;
    logic [15:0]       req_len;
    logic [31:0]       req_size;
    logic [CNT_W-1:0]  full_count;

    assign req_len    = req_cmd.is_long ? req_cmd.arg : 16'd0;
    assign req_size   = 32'(req_len) + 32'(HDR_BYTES);
    assign full_count = CNT_W'(cmd.is_long ? cmd.arg : 16'd0) + CNT_W'(HDR_BYTES);

    assign req_ready = (phase == PH_IDLE);
    assign flush     = (phase == PH_FLUSH);
    assign head_now  = (phase == PH_HEAD);
    assign pay_ready = (phase == PH_BODY);
    assign pay_last  = (remain == 16'd1);
    assign tx_trig   = (phase == PH_KICK);
    assign bta_req   = (phase == PH_TURN);
    assign done      = (phase == PH_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            remain <= '0;
            timer  <= '0;
            status <= XS_OK;
            count  <= '0;
            vfifo  <= 1'b0;
            cmd    <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (req_valid) begin
                    cmd    <= req_cmd;
                    remain <= req_len;
                    timer  <= '0;
                    vfifo  <= (req_size > HOST_BYTES);
                    if (req_size > VIDEO_BYTES) begin
                        status <= XS_NOSPACE;
                        count  <= '0;
                        phase  <= PH_FIN;
                    end else if (fifo_bad) begin
                        phase <= PH_FLUSH;
                    end else begin
                        phase <= PH_HEAD;
                    end
                end
                PH_FLUSH: phase <= PH_HEAD;
                PH_HEAD:  phase <= (remain != 16'd0) ? PH_BODY : PH_KICK;
                PH_BODY: if (pay_valid) begin
                    remain <= remain - 16'd1;
                    if (remain == 16'd1) phase <= PH_KICK;
                end
                PH_KICK: begin
                    if (trig_clr) begin
                        status <= XS_OK;
                        count  <= cmd.want_bta ? '0 : full_count;
                        phase  <= cmd.want_bta ? PH_TURN : PH_FIN;
                    end else if (({1'b0, timer} + 1'b1) >= {1'b0, cfg_timeout}) begin
                        status <= XS_TIMEOUT;
                        count  <= '0;
                        phase  <= PH_FIN;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                PH_TURN: phase <= PH_FIN;
                PH_FIN:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx
    import dsi_tx_pkg::*;
#(
    parameter int HOST_WORDS  = 64,
    parameter int VIDEO_WORDS = 480,
    parameter int TO_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TO_W-1:0]  cfg_timeout,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [5:0]       req_dtype,
    input  logic [1:0]       req_vc,
    input  logic             req_long,
    input  logic [15:0]      req_arg,
    input  logic             req_ack,
    input  logic             req_read,
    input  logic             fifo_uflow,
    input  logic             fifo_oflow,
    input  logic             pay_valid,
    output logic             pay_ready,
    input  logic [7:0]       pay_byte,
    output logic             fifo_rst,
    output logic             wd_valid,
    output logic [31:0]      wd_data,
    output logic             wd_vfifo,
    output logic             tx_trig,
    input  logic             trig_clr,
    output logic             bta_req,
    output logic             done,
    output logic [1:0]       done_status,
    output logic [16:0]      done_count
);
    cmd_t         req_cmd;
    cmd_t         cur_cmd;
    xfer_status_e st;
    logic         head_now;
    logic         pay_last;
    logic [31:0]  head_word;
    logic [31:0]  head_q;
    logic         head_valid_q;
    logic         pk_valid;
    logic [31:0]  pk_word;

    assign req_cmd = '{dtype:    req_dtype,
                       vc:       req_vc,
                       is_long:  req_long,
                       arg:      req_arg,
                       want_bta: req_ack | req_read};

    dsi_tx_seq #(
        .HOST_WORDS (HOST_WORDS),
        .VIDEO_WORDS(VIDEO_WORDS),
        .TO_W       (TO_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_timeout(cfg_timeout),
        .req_valid  (req_valid),
        .req_cmd    (req_cmd),
        .fifo_bad   (fifo_uflow | fifo_oflow),
        .pay_valid  (pay_valid),
        .trig_clr   (trig_clr),
        .req_ready  (req_ready),
        .flush      (fifo_rst),
        .head_now   (head_now),
        .pay_ready  (pay_ready),
        .pay_last   (pay_last),
        .tx_trig    (tx_trig),
        .bta_req    (bta_req),
        .done       (done),
        .status     (st),
        .count      (done_count),
        .vfifo      (wd_vfifo),
        .cmd        (cur_cmd)
    );

    dsi_tx_hdr u_hdr (
        .cmd (cur_cmd),
        .word(head_word)
    );

    dsi_tx_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .take      (pay_valid & pay_ready),
        .last      (pay_last),
        .data      (pay_byte),
        .word_valid(pk_valid),
        .word      (pk_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_valid_q <= 1'b0;
            head_q       <= '0;
        end else begin
            head_valid_q <= head_now;
            if (head_now) head_q <= head_word;
        end
    end

    assign wd_valid    = head_valid_q | pk_valid;
    assign wd_data     = head_valid_q ? head_q : pk_word;
    assign done_status = st;
endmodule

// File: rtl/dsi_cmd_tx_chk.sv
module dsi_cmd_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       fifo_uflow,
    input logic       fifo_oflow,
    input logic       pay_ready,
    input logic       fifo_rst,
    input logic       wd_valid,
    input logic       tx_trig,
    input logic       trig_clr,
    input logic       bta_req,
    input logic       done,
    input logic [1:0] done_status
);
    // R8: turnaround only right after the trigger phase
    a_r8_turn_after_trigger: assert property (@(posedge clk) disable iff (rst)
        bta_req |-> $past(tx_trig) && $past(trig_clr));

    // R11: completion is a single-cycle pulse
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: idle excludes all transfer activity
    a_r11_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !tx_trig && !pay_ready && !wd_valid && !bta_req);

    // R5: refusal completes in the cycle after acceptance
    a_r5_reject_direct: assert property (@(posedge clk) disable iff (rst)
        (done && done_status == 2'd1) |-> $past(req_valid && req_ready));

    // R10: FIFO reset follows an acceptance with a flag set
    a_r10_flush_after_accept: assert property (@(posedge clk) disable iff (rst)
        fifo_rst |-> $past(req_valid && req_ready && (fifo_uflow || fifo_oflow)));

    // R7: timeout ends a trigger phase that saw no clear
    a_r7_timeout_from_trigger: assert property (@(posedge clk) disable iff (rst)
        (done && done_status == 2'd2) |-> $past(tx_trig) && !$past(trig_clr));

    // R6: trigger held until cleared or timed out
    a_r6_trigger_held: assert property (@(posedge clk) disable iff (rst)
        (tx_trig && !trig_clr) |=> (tx_trig || done));
endmodule

bind dsi_cmd_tx dsi_cmd_tx_chk u_chk (.*);

// File: tb/tb_dsi_cmd_tx.sv
module tb_dsi_cmd_tx;
    localparam int HW   = 4;
    localparam int VW   = 8;
    localparam int TO_W = 8;

    localparam logic [5:0] SYN [24] = '{
        6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
        6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
        6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [TO_W-1:0] cfg_timeout = 8'd20;
    logic req_valid = 1'b0, req_ready;
    logic [5:0] req_dtype = '0;
    logic [1:0] req_vc = '0;
    logic req_long = 1'b0;
    logic [15:0] req_arg = '0;
    logic req_ack = 1'b0, req_read = 1'b0;
    logic fifo_uflow = 1'b0, fifo_oflow = 1'b0;
    logic pay_valid = 1'b0, pay_ready;
    logic [7:0] pay_byte;
    logic fifo_rst, wd_valid, wd_vfifo, tx_trig, bta_req, done;
    logic trig_clr = 1'b0;
    logic [31:0] wd_data;
    logic [1:0] done_status;
    logic [16:0] done_count;

    always #10 clk = ~clk;

    dsi_cmd_tx #(.HOST_WORDS(HW), .VIDEO_WORDS(VW), .TO_W(TO_W)) dut (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0] pbuf [64];
    int pidx = 0;
    assign pay_byte = pbuf[pidx % 64];

    logic [31:0] exp_q [$];
    logic exp_vf = 1'b0;
    int widx = 0, rst_seen = 0, bta_seen = 0, trig_cyc = 0, trig_run = 0;
    int clr_delay = 3;
    bit done_seen = 0;
    logic [1:0] got_st;
    logic [16:0] got_cnt;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_ecc(input logic [23:0] h);
        logic [5:0] e = '0;
        for (int i = 0; i < 24; i++) if (h[i]) e ^= SYN[i];
        return e;
    endfunction

    always @(posedge clk) if (pay_valid && pay_ready) pidx <= pidx + 1;

    // per-clock comparison against the expected stream
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (wd_valid) begin
                if (exp_q.size() == 0) chk(0, "R3", "unexpected word", wd_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(wd_data == e, widx == 0 ? "R1" : "R3", "word", wd_data, e);
                    chk(wd_vfifo == exp_vf, "R4", "fifo select", wd_vfifo, exp_vf);
                end
                widx++;
            end
            if (fifo_rst) rst_seen++;
            if (bta_req) bta_seen++;
            if (done) begin
                done_seen = 1;
                got_st = done_status;
                got_cnt = done_count;
            end
            if (tx_trig) begin trig_cyc++; trig_run++; end
            else trig_run = 0;
            trig_clr = tx_trig && clr_delay > 0 && trig_run == clr_delay;
        end
    end

    task automatic xfer(input logic [5:0] dt, input logic [1:0] vc, input bit lng,
                        input logic [15:0] arg, input bit ack, input bit rd,
                        input bit uf, input bit of, input int cd, input string tag);
        int len, size, est, ecnt;
        bit ebta, erst;
        logic [23:0] h;
        len = lng ? int'(arg) : 0;
        size = 4 + len;
        for (int i = 0; i < 64; i++) pbuf[i] = 8'(i * 37 + int'(dt) + 5);
        exp_q.delete();
        if (size > VW * 4) est = 1;
        else if (cd <= 0 || cd > int'(cfg_timeout)) est = 2;
        else est = 0;
        ebta = (est == 0) && (ack || rd);
        erst = (est != 1) && (uf || of);
        ecnt = (est == 0 && !ebta) ? size : 0;
        exp_vf = size > HW * 4;
        if (est != 1) begin
            h = {arg, vc, dt};
            exp_q.push_back({2'b00, ref_ecc(h), h});
            for (int j = 0; j < len; j += 4) begin
                logic [31:0] w = '0;
                for (int k = 0; k < 4; k++) if (j + k < len) w[k*8 +: 8] = pbuf[j + k];
                exp_q.push_back(w);
            end
        end
        widx = 0; rst_seen = 0; bta_seen = 0; trig_cyc = 0; done_seen = 0;
        clr_delay = cd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        pidx = 0;
        req_dtype = dt; req_vc = vc; req_long = lng; req_arg = arg;
        req_ack = ack; req_read = rd; fifo_uflow = uf; fifo_oflow = of;
        req_valid = 1'b1; pay_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; fifo_uflow = 1'b0; fifo_oflow = 1'b0;
        for (int t = 0; t < 2000 && !done_seen; t++) @(negedge clk);
        pay_valid = 1'b0;
        chk(done_seen, "R11", {tag, " completion seen"}, done_seen, 1);
        chk(got_st == 2'(est), est == 1 ? "R5" : (est == 2 ? "R7" : "R6"),
            {tag, " status"}, got_st, est);
        chk(got_cnt == 17'(ecnt), "R9", {tag, " count"}, got_cnt, ecnt);
        chk(bta_seen == int'(ebta), "R8", {tag, " turnaround"}, bta_seen, ebta);
        chk(rst_seen == int'(erst), "R10", {tag, " fifo reset"}, rst_seen, erst);
        chk(exp_q.size() == 0, "R3", {tag, " words left"}, exp_q.size(), 0);
        chk(pidx == (est == 1 ? 0 : len), "R3", {tag, " payload beats"}, pidx, len);
        if (est == 1) chk(trig_cyc == 0, "R5", {tag, " trigger"}, trig_cyc, 0);
        else if (est == 2) chk(trig_cyc == int'(cfg_timeout), "R7", {tag, " trigger cycles"},
                               trig_cyc, cfg_timeout);
        else chk(trig_cyc == cd, "R6", {tag, " trigger cycles"}, trig_cyc, cd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "reset ready", req_ready, 1);
        chk(!wd_valid && !tx_trig && !done && !fifo_rst && !bta_req && !pay_ready,
            "R11", "reset outputs quiet", 0, 0);
        xfer(6'h15, 2'd0, 0, 16'h1234, 0, 0, 0, 0, 3, "R1 short write");
        xfer(6'h3F, 2'd3, 0, 16'hFFFF, 0, 0, 0, 0, 1, "R2 all ones header");
        xfer(6'h06, 2'd1, 0, 16'h00A5, 0, 1, 0, 0, 2, "R8 short read");
        xfer(6'h39, 2'd2, 1, 16'd0, 0, 0, 0, 0, 2, "R3 long empty");
        xfer(6'h39, 2'd0, 1, 16'd5, 0, 0, 0, 0, 4, "R3 padded tail");
        xfer(6'h29, 2'd1, 1, 16'd12, 0, 0, 0, 0, 2, "R4 host limit");
        xfer(6'h29, 2'd1, 1, 16'd13, 1, 0, 0, 0, 2, "R4 video select");
        xfer(6'h39, 2'd3, 1, 16'd28, 0, 0, 0, 0, 1, "R5 largest accepted");
        xfer(6'h39, 2'd0, 1, 16'd29, 1, 0, 1, 0, 2, "R5 refused");
        xfer(6'h39, 2'd0, 1, 16'hFFFF, 0, 0, 0, 0, 2, "R5 huge refused");
        xfer(6'h05, 2'd0, 0, 16'h0011, 0, 0, 1, 0, 2, "R10 underflow");
        xfer(6'h39, 2'd2, 1, 16'd3, 0, 0, 0, 1, 2, "R10 overflow");
        cfg_timeout = 8'd6;
        xfer(6'h05, 2'd0, 0, 16'h0028, 1, 0, 0, 0, 0, "R7 no clear");
        xfer(6'h05, 2'd0, 0, 16'h0028, 0, 0, 0, 0, 6, "R7 clear at budget");
        xfer(6'h05, 2'd0, 0, 16'h0028, 0, 0, 0, 0, 7, "R7 clear too late");
        cfg_timeout = 8'd1;
        xfer(6'h14, 2'd1, 0, 16'h0102, 0, 1, 0, 0, 1, "R8 read budget one");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog: actual %0d expected 0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule